// File: doc/BRIEF.md
# Three-Level Interrupt Priority Controller

This block arbitrates thirteen interrupt requests for a small processor core. Source 0 is the power-fail request. It always sits on its own top level. Sources 1 to 12 are each placed on the high or the low level by a per-source priority bit. Every cycle the block looks at the pending, enabled requests and picks one winner. The winner is the request on the highest level, and within that level the lowest source index. The winner is taken only if its level is strictly above every level that is already being serviced.

When a request is taken, the block raises a one-cycle accept strobe and presents the index of the winning source. It also marks the winner's level as in service. A return-from-interrupt pulse from the core ends the most recent service, which is the highest level still in service. The in-service state of all three levels is visible on a 3-bit status output. This lets the core nest handlers: a low-level handler can be cut short by a high or power-fail request, but never by a request on its own level or a lower one.

The natural index order within a level is fixed:

| Index | Source |
|---|---|
| 1 | external 0 |
| 2 | timer 0 |
| 3 | external 1 |
| 4 | timer 1 |
| 5 | serial 0 |
| 6 | timer 2 |
| 7 | serial 1 |
| 8 to 11 | four extra externals |
| 12 | watchdog |

Top module: `irq_prio_ctl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `take_o` is 0, `vec_o` is 0 and `svc_o` is 3'b000.
- R2: Source 0 is always on the power-fail level, whatever `hi_prio_i[0]` holds, and it wins over any high or low request.
- R3: A source with index 1 to 12 is on the high level when its `hi_prio_i` bit is 1 and on the low level when it is 0. A high-level request wins over a low-level one.
- R4: When several eligible requests share the winning level, the one with the lowest index wins.
- R5: A request is eligible only when its `pend_i` and `en_i` bits are both 1. Sources 1 to 12 also need `gen_i` = 1. Source 0 ignores `gen_i` but needs `en_i[0]`.
- R6: A request is taken only if its level is strictly above the highest level set in `svc_o`. A request on an equal or lower level waits without any change at the outputs.
- R7: One cycle after the edge that samples a request, the accepted request shows as follows:
  - `take_o` is 1 for exactly that cycle.
  - `vec_o` shows the winning index, and keeps it until the next acceptance.
  - The winner's level bit is set in `svc_o` in the same cycle.
- R8: A `reti_i` pulse clears only the highest set bit of `svc_o`. No request is taken in a cycle where `reti_i` is sampled high.
- R9: A `reti_i` pulse while `svc_o` is 3'b000 leaves `svc_o` at 3'b000.
- R10: In `svc_o`, bit 2 is the power-fail level, bit 1 is the high level and bit 0 is the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_i | input | 13 | Per-source pending request flags |
| en_i | input | 13 | Per-source enable bits |
| gen_i | input | 1 | Global enable for sources 1 to 12 |
| hi_prio_i | input | 13 | Per-source level select, 1 = high (bit 0 unused) |
| reti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | Accept strobe, one cycle per accepted request |
| vec_o | output | 4 | Index of the last accepted source |
| svc_o | output | 3 | In-service bits {power-fail, high, low} |

## Verification
A corrupted in-service register shows up in two ways. It either blocks a legal pre-emption or lets an equal-level request through. Both appear at `take_o` on the first cycle a request of the affected level is presented, which is one edge after the bad state forms. A wrong clear on return shows at `svc_o` one cycle after the `reti_i` pulse. It shows again later as a re-take of a pending request that should still be blocked. Mistakes in picking the winner or in mapping a source to its level show at `vec_o` in the same cycle as the strobe. The sequences therefore stack levels, return out of them one at a time, and keep requests pending across returns.

// File: rtl/irq_pkg.sv
// Package: shared sizes and level numbering for the interrupt priority
// controller. Level numbers double as bit positions in the in-service field.
package irq_pkg;
    localparam int unsigned SRC_COUNT = 13;
    localparam int unsigned LVL_COUNT = 3;
    localparam int unsigned LVL_LO    = 0;
    localparam int unsigned LVL_HI    = 1;
    localparam int unsigned LVL_PF    = 2;
    localparam int unsigned PF_SRC    = 0;
endpackage

// File: rtl/irq_level_map.sv
// Module: irq_level_map
// Places every source on one of three levels and returns one request
// vector per level. The power-fail source is pinned to the top level;
// the rest follow their high/low bit. Assumes PF_IDX < N.
module irq_level_map #(
    parameter int unsigned N      = 13,
    parameter int unsigned PF_IDX = 0
) (
    input  logic [N-1:0] elig_i,
    input  logic [N-1:0] hi_i,
    output logic [N-1:0] req_pf_o,
    output logic [N-1:0] req_hi_o,
    output logic [N-1:0] req_lo_o
);
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_src
            if (gi == PF_IDX) begin : g_pf
                // power-fail source: fixed top level, priority bit ignored
                assign req_pf_o[gi] = elig_i[gi];
                assign req_hi_o[gi] = 1'b0;
                assign req_lo_o[gi] = 1'b0;
            end else begin : g_sw
                // software-assigned source: high or low by its bit
                assign req_pf_o[gi] = 1'b0;
                assign req_hi_o[gi] = elig_i[gi] & hi_i[gi];
                assign req_lo_o[gi] = elig_i[gi] & ~hi_i[gi];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_pick.sv
// Module: irq_pick
// Fixed-order picker: reports whether any request is set and the index
// of the lowest set bit. Purely combinational.
module irq_pick #(
    parameter int unsigned N  = 13,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // scan from the top so the lowest index is written last and wins
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/irq_svc_track.sv
// Module: irq_svc_track
// Holds one in-service bit per level. An accepted request sets its level
// bit; a return clears the highest set bit only. Assumes the caller never
// raises acc_v_i in a cycle with ret_i.
module irq_svc_track #(
    parameter int unsigned NL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_v_i,
    input  logic [NL-1:0] acc_lvl_i,
    input  logic          ret_i,
    output logic [NL-1:0] svc_o
);
    logic [NL-1:0] svc_q;
    logic [NL-1:0] top_bit;

    // isolate the highest set in-service bit
    always_comb begin
        top_bit = '0;
        for (int i = 0; i < NL; i++) begin
            if (svc_q[i]) top_bit = NL'(1) << i;
        end
    end

    // update in-service state on return or acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= '0;
        end else if (ret_i) begin
            svc_q <= svc_q & ~top_bit;
        end else if (acc_v_i) begin
            svc_q <= svc_q | acc_lvl_i;
        end
    end

    assign svc_o = svc_q;

    // accepted level must be strictly above everything in service
    assert_strict_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_v_i |-> ((svc_q & ~(acc_lvl_i - NL'(1))) == '0));

    // a return drops exactly one in-service level
    assert_ret_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && (svc_q != '0)) |=> ($countones(svc_q) == $countones($past(svc_q)) - 1));

    // a return with nothing in service changes nothing
    assert_ret_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && (svc_q == '0)) |=> (svc_q == '0));
endmodule

// File: rtl/irq_prio_ctl.sv
// Module: irq_prio_ctl
// Three-level interrupt priority controller. Gates the requests by their
// enables, sorts them onto levels, picks the lowest index per level, and
// accepts the top candidate when its level beats everything in service.
// Outputs are registered; an accepted request shows one edge after it is
// sampled. Assumes pending flags are cleared elsewhere.
module irq_prio_ctl #(
    parameter int unsigned NSRC = irq_pkg::SRC_COUNT,
    parameter int unsigned PF   = irq_pkg::PF_SRC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         pend_i,
    input  logic [NSRC-1:0]         en_i,
    input  logic                    gen_i,
    input  logic [NSRC-1:0]         hi_prio_i,
    input  logic                    reti_i,
    output logic                    take_o,
    output logic [$clog2(NSRC)-1:0] vec_o,
    output logic [irq_pkg::LVL_COUNT-1:0] svc_o
);
    import irq_pkg::*;

    localparam int unsigned IW = $clog2(NSRC);
    localparam int unsigned NL = LVL_COUNT;

    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] req_lv [NL];
    logic [NL-1:0]   pick_v;
    logic [IW-1:0]   pick_idx [NL];
    logic            sel_v;
    logic [NL-1:0]   sel_lvl;
    logic [IW-1:0]   sel_idx;
    logic            acc_v;
    logic            take_q;
    logic [IW-1:0]   vec_q;

    // eligibility: global enable gates everything except power-fail
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = pend_i[i] & en_i[i] & ((i == PF) ? 1'b1 : gen_i);
        end
    end

    irq_level_map #(.N(NSRC), .PF_IDX(PF)) u_map (
        .elig_i   (elig),
        .hi_i     (hi_prio_i),
        .req_pf_o (req_lv[LVL_PF]),
        .req_hi_o (req_lv[LVL_HI]),
        .req_lo_o (req_lv[LVL_LO])
    );

    genvar gl;
    generate
        for (gl = 0; gl < NL; gl++) begin : g_lvl
            irq_pick #(.N(NSRC), .IW(IW)) u_pick (
                .req_i (req_lv[gl]),
                .any_o (pick_v[gl]),
                .idx_o (pick_idx[gl])
            );

            // per-level pick is a set bit with no lower set bit
            assert_pick_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
                pick_v[gl] |-> (req_lv[gl][pick_idx[gl]] &&
                    ((req_lv[gl] & ((NSRC'(1) << pick_idx[gl]) - NSRC'(1))) == '0)));
        end
    endgenerate

    // choose the highest level whose candidate beats the in-service field
    always_comb begin
        sel_v   = 1'b0;
        sel_lvl = '0;
        sel_idx = '0;
        for (int l = 0; l < NL; l++) begin
            if (pick_v[l] && ((svc_o >> l) == '0)) begin
                sel_v   = 1'b1;
                sel_lvl = NL'(1) << l;
                sel_idx = pick_idx[l];
            end
        end
        acc_v = sel_v & ~reti_i;
    end

    irq_svc_track #(.NL(NL)) u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_v_i   (acc_v),
        .acc_lvl_i (sel_lvl),
        .ret_i     (reti_i),
        .svc_o     (svc_o)
    );

    // register the strobe and hold the last accepted index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= acc_v;
            if (acc_v) vec_q <= sel_idx;
        end
    end

    assign take_o = take_q;
    assign vec_o  = vec_q;

    // power-fail acceptance always lands in the top in-service bit
    assert_pf_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (vec_o == IW'(PF))) |-> svc_o[LVL_PF]);

    // no acceptance follows a return cycle
    assert_reti_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !take_o);

    // each strobe adds exactly one in-service level
    assert_take_adds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($countones(svc_o) == $countones($past(svc_o)) + 1));
endmodule

// File: tb/test_irq_prio_ctl.sv
// Scoreboard bench: the driver applies one cycle of stimulus and queues
// the expected outputs; the monitor compares them at the next falling edge.
module test_irq_prio_ctl;
    localparam int NS = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] pend = '0, en = '0, hi = '0;
    logic          gen = 1'b0, reti = 1'b0;
    logic          take;
    logic [3:0]    vec;
    logic [2:0]    svc;

    int n_chk = 0, n_err = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         done = 1'b0;

    always #2 clk = ~clk;

    irq_prio_ctl i_irq_prio_ctl (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .gen_i(gen),
        .hi_prio_i(hi), .reti_i(reti), .take_o(take), .vec_o(vec), .svc_o(svc)
    );

    // monitor: compare the queued expectation with the outputs
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if ({take, vec, svc} !== e) begin
                n_err++;
                $display("FAIL %s: take=%0b vec=%0d svc=%03b expected take=%0b vec=%0d svc=%03b",
                         t, take, vec, svc, e[7], e[6:3], e[2:0]);
            end
        end
    end

    // driver: one cycle of stimulus, then queue the expected result
    task automatic step(input logic [NS-1:0] p, input logic [NS-1:0] e_n,
                        input logic g, input logic [NS-1:0] h, input logic r,
                        input logic x_take, input int x_vec, input logic [2:0] x_svc,
                        input string tag);
        @(negedge clk);
        #0;
        pend = p; en = e_n; gen = g; hi = h; reti = r;
        @(posedge clk);
        #1;
        exp_q.push_back({x_take, 4'(x_vec), x_svc});
        tag_q.push_back(tag);
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    localparam logic [NS-1:0] ALL = '1;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if ({take, vec, svc} !== 8'h00) begin
            n_err++;
            $display("FAIL R1 in reset: got %0b/%0d/%03b expected 0/0/000", take, vec, svc);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step('0, ALL, 1, '0, 0, 0, 0, 3'b000, "R1 after release");
        // two low requests: lowest index wins
        step(13'h00C, ALL, 1, '0, 0, 1, 2, 3'b001, "R4 R7 low pick");
        // same-level request waits
        step(13'h008, ALL, 1, '0, 0, 0, 2, 3'b001, "R6 equal level waits");
        // high request pre-empts low
        step(13'h1008, ALL, 1, 13'h1000, 0, 1, 12, 3'b011, "R3 high preempts");
        // power-fail ignores gen and its hi bit
        step(13'h001, ALL, 0, 13'h1000, 0, 1, 0, 3'b111, "R2 R5 power-fail");
        step('0, ALL, 1, '0, 1, 0, 0, 3'b011, "R8 reti clears pf only");
        step(13'h020, ALL, 1, 13'h020, 0, 0, 0, 3'b011, "R6 high waits on high");
        step(13'h020, ALL, 1, 13'h020, 1, 0, 0, 3'b001, "R8 no take on reti");
        step(13'h020, ALL, 1, 13'h020, 0, 1, 5, 3'b011, "R6 high over low");
        step('0, ALL, 1, '0, 1, 0, 5, 3'b001, "R8 reti clears high");
        step('0, ALL, 1, '0, 1, 0, 5, 3'b000, "R8 reti clears low");
        step('0, ALL, 1, '0, 1, 0, 5, 3'b000, "R9 reti when empty");
        step(13'h002, ALL & ~13'h002, 1, '0, 0, 0, 5, 3'b000, "R5 source disabled");
        step(13'h002, ALL, 0, '0, 0, 0, 5, 3'b000, "R5 global disable");
        step(13'h902, ALL, 1, 13'h900, 0, 1, 8, 3'b010, "R3 R4 high among mix");
        step(13'h002, ALL, 1, '0, 0, 0, 8, 3'b010, "R6 low below high");
        step(13'h002, ALL, 1, '0, 1, 0, 8, 3'b000, "R8 reti blocks pending low");
        step(13'h002, ALL, 1, '0, 0, 1, 1, 3'b001, "R7 low retaken");
        step(13'h001, ALL & ~13'h001, 1, '0, 0, 0, 1, 3'b001, "R5 pf own enable");
        step(13'h001, ALL, 1, 13'h001, 0, 1, 0, 3'b101, "R10 pf bit position");
        step('0, ALL, 1, '0, 0, 0, 0, 3'b101, "R7 strobe one cycle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule